// File: doc/BRIEF.md
# Multithreaded Windowed Register File

This block stores the integer registers of several hardware threads. Each thread sees 32 registers at a time: eight globals shared by all of its windows, plus a window of outs, locals and ins. Windows overlap. The ins of one window are the same storage as the outs of the window reached by one more restore, so a caller's outgoing arguments appear as the callee's incoming ones after a save, and no data is copied. A thread's private storage is its globals plus sixteen entries per window. The physical entry is formed from the thread number, that thread's current window pointer and the 5-bit register number.

Three read ports return data combinationally, and two write ports update storage at the rising clock edge. Every port names its own thread, so different threads can be served in the same cycle. One save or restore command per cycle moves the window pointer of the thread it names. A save that would reach a window still holding live data does not move the pointer and raises an overflow pulse for that thread. A restore with no saved window behind it raises an underflow pulse in the same way. Spilling and filling windows to memory is left to whatever consumes those pulses.

Top module: `rwin_regfile`

## Requirements
- R1: After a synchronous active-high reset, every window pointer is 0, both flag vectors are 0, and every register of every thread reads 0.
- R2: Register 0 always reads 0, and a write to register 0 leaves all storage unchanged.
- R3: Registers 1..7 (globals) are shared by all windows of one thread and are separate for each thread.
- R4: Registers 16..23 (locals) are separate for each window of a thread.
- R5: Registers 24..31 (ins) of window w are the same storage as registers 8..15 (outs) of window (w+1) mod NUM_WINDOWS.
- R6: An accepted save decrements the named thread's window pointer modulo NUM_WINDOWS (a power of two), and an accepted restore increments it. The new value appears on winPtr one clock after the command.
- R7: A thread may hold at most NUM_WINDOWS-2 saves that have not been restored. A save beyond that limit leaves the pointer unchanged and drives that thread's bit of overflowFlag high for exactly the one cycle after the command.
- R8: A restore while the thread has no outstanding save leaves the pointer unchanged and drives that thread's bit of underflowFlag high for exactly the one cycle after the command.
- R9: Asserting saveEn and restoreEn together changes no pointer and raises no flag.
- R10: Each of the three read ports independently returns, in the same cycle, the register selected by its own thread and register number in that thread's current window, including data written at the previous edge.
- R11: When both write ports target the same physical register in one cycle, the value from port 0 is stored.
- R12: A write issued in the same cycle as a save or restore of the same thread lands in the window that was current before the pointer moves.
- R13: Each thread keeps its own window pointer. A command for one thread never changes another thread's pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rdThread | input | NUM_RD*THREAD_W | Thread selected by each read port |
| rdReg | input | NUM_RD*5 | Register number for each read port |
| rdData | output | NUM_RD*DATA_W | Combinational read data for each port |
| wrEn | input | NUM_WR | Write enable for each write port |
| wrThread | input | NUM_WR*THREAD_W | Thread selected by each write port |
| wrReg | input | NUM_WR*5 | Register number for each write port |
| wrData | input | NUM_WR*DATA_W | Write data for each port |
| saveEn | input | 1 | Save command (move window pointer down) |
| restoreEn | input | 1 | Restore command (move window pointer up) |
| opThread | input | THREAD_W | Thread named by the save/restore command |
| winPtr | output | NUM_THREADS*WIN_W | Current window pointer of every thread |
| overflowFlag | output | NUM_THREADS | One-cycle pulse per thread on a refused save |
| underflowFlag | output | NUM_THREADS | One-cycle pulse per thread on a refused restore |

## Verification
The case that needs the most care is a register write and a window move for the same thread in the same cycle. The write must use the pointer from before the move, and the refused-save path must still let the write through. A directed cycle writes an out register together with a save and then reads the matching in register of the new window. The random phase also often lines up writes with saves and restores, including refused ones, on the same thread. Every result is compared against a bench model that applies the writes with the old pointer and only then moves the pointer.

// File: rtl/rwin_pkg.sv
package rwin_pkg;
  localparam int REG_NUM_W = 5;
  localparam int GROUP_SIZE = 8;
  localparam int WIN_SLOTS = 2 * GROUP_SIZE;

  typedef struct packed {
    logic stepDown;
    logic stepUp;
  } winStrobe_t;

  typedef enum logic [1:0] {
    OP_IDLE    = 2'd0,
    OP_SAVE    = 2'd1,
    OP_RESTORE = 2'd2,
    OP_CLASH   = 2'd3
  } winOp_e;
endpackage

// File: rtl/rwin_ctrl.sv
module rwin_ctrl
  import rwin_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int NUM_WINDOWS = 8,
  parameter int THREAD_W = $clog2(NUM_THREADS)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   saveEn,
  input  logic                   restoreEn,
  input  logic [THREAD_W-1:0]    opThread,
  output winStrobe_t             strobe,
  output logic [NUM_THREADS-1:0] overflowFlag,
  output logic [NUM_THREADS-1:0] underflowFlag
);
  localparam int DEPTH_W = $clog2(NUM_WINDOWS);
  localparam logic [DEPTH_W-1:0] MAX_DEPTH = DEPTH_W'(NUM_WINDOWS - 2);

  logic [NUM_THREADS-1:0][DEPTH_W-1:0] depthQ;
  winOp_e op;
  logic atLimit, atEmpty;

  always_comb begin
    unique case ({restoreEn, saveEn})
      2'b01:   op = OP_SAVE;
      2'b10:   op = OP_RESTORE;
      2'b11:   op = OP_CLASH;
      default: op = OP_IDLE;
    endcase
    atLimit = (depthQ[opThread] == MAX_DEPTH);
    atEmpty = (depthQ[opThread] == '0);
    strobe.stepDown = (op == OP_SAVE) && !atLimit;
    strobe.stepUp   = (op == OP_RESTORE) && !atEmpty;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      depthQ        <= '0;
      overflowFlag  <= '0;
      underflowFlag <= '0;
    end else begin
      for (int t = 0; t < NUM_THREADS; t++) begin
        overflowFlag[t]  <= 1'b0;
        underflowFlag[t] <= 1'b0;
        if (opThread == THREAD_W'(t)) begin
          if (strobe.stepDown) depthQ[t] <= depthQ[t] + DEPTH_W'(1);
          if (strobe.stepUp)   depthQ[t] <= depthQ[t] - DEPTH_W'(1);
          if (op == OP_SAVE && atLimit)    overflowFlag[t]  <= 1'b1;
          if (op == OP_RESTORE && atEmpty) underflowFlag[t] <= 1'b1;
        end
      end
    end
  end

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_chk
    p_depth_limit_r7: assert property (@(posedge clk) disable iff (rst)
      depthQ[t] <= MAX_DEPTH);
    p_overflow_cause_r7: assert property (@(posedge clk) disable iff (rst)
      overflowFlag[t] |-> $past(saveEn && !restoreEn && opThread == THREAD_W'(t)));
    p_underflow_cause_r8: assert property (@(posedge clk) disable iff (rst)
      underflowFlag[t] |-> $past(restoreEn && !saveEn && opThread == THREAD_W'(t)));
  end

  p_clash_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (saveEn && restoreEn) |=> (overflowFlag == '0 && underflowFlag == '0));
endmodule

// File: rtl/rwin_datapath.sv
module rwin_datapath
  import rwin_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int NUM_WINDOWS = 8,
  parameter int DATA_W = 32,
  parameter int NUM_RD = 3,
  parameter int NUM_WR = 2,
  parameter int THREAD_W = $clog2(NUM_THREADS),
  parameter int WIN_W = $clog2(NUM_WINDOWS)
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  winStrobe_t                            strobe,
  input  logic [THREAD_W-1:0]                   opThread,
  input  logic [NUM_RD-1:0][THREAD_W-1:0]       rdThread,
  input  logic [NUM_RD-1:0][REG_NUM_W-1:0]      rdReg,
  output logic [NUM_RD-1:0][DATA_W-1:0]         rdData,
  input  logic [NUM_WR-1:0]                     wrEn,
  input  logic [NUM_WR-1:0][THREAD_W-1:0]       wrThread,
  input  logic [NUM_WR-1:0][REG_NUM_W-1:0]      wrReg,
  input  logic [NUM_WR-1:0][DATA_W-1:0]         wrData,
  output logic [NUM_THREADS-1:0][WIN_W-1:0]     winPtr
);
  localparam int PER_THREAD = GROUP_SIZE + WIN_SLOTS * NUM_WINDOWS;
  localparam int ENTRIES = NUM_THREADS * PER_THREAD;
  localparam int IDX_W = $clog2(ENTRIES);

  logic [DATA_W-1:0] store [ENTRIES];
  logic [NUM_THREADS-1:0][WIN_W-1:0] cwpQ;
  logic [NUM_RD-1:0][IDX_W-1:0] rdIdx;
  logic [NUM_WR-1:0][IDX_W-1:0] wrIdx;

  function automatic logic [IDX_W-1:0] physIdx(input int th, input int w, input int r);
    int win, slot, flat;
    win = (r >= 24) ? ((w + 1) % NUM_WINDOWS) : w;
    if (r >= 24)      slot = r - 24;
    else if (r >= 16) slot = GROUP_SIZE + (r - 16);
    else              slot = r - 8;
    if (r < GROUP_SIZE) flat = th * PER_THREAD + r;
    else                flat = th * PER_THREAD + GROUP_SIZE + win * WIN_SLOTS + slot;
    return IDX_W'(flat);
  endfunction

  always_comb begin
    for (int p = 0; p < NUM_RD; p++) begin
      rdIdx[p]  = physIdx(int'(rdThread[p]), int'(cwpQ[rdThread[p]]), int'(rdReg[p]));
      rdData[p] = (rdReg[p] == '0) ? '0 : store[rdIdx[p]];
    end
    for (int p = 0; p < NUM_WR; p++)
      wrIdx[p] = physIdx(int'(wrThread[p]), int'(cwpQ[wrThread[p]]), int'(wrReg[p]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int e = 0; e < ENTRIES; e++) store[e] <= '0;
    end else begin
      for (int p = NUM_WR - 1; p >= 0; p--)
        if (wrEn[p] && wrReg[p] != '0) store[wrIdx[p]] <= wrData[p];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cwpQ <= '0;
    end else if (strobe.stepDown) begin
      cwpQ[opThread] <= cwpQ[opThread] - WIN_W'(1);
    end else if (strobe.stepUp) begin
      cwpQ[opThread] <= cwpQ[opThread] + WIN_W'(1);
    end
  end

  assign winPtr = cwpQ;

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_ptr
    p_ptr_down_r6: assert property (@(posedge clk) disable iff (rst)
      (strobe.stepDown && opThread == THREAD_W'(t)) |=> cwpQ[t] == $past(cwpQ[t]) - WIN_W'(1));
    p_ptr_up_r6: assert property (@(posedge clk) disable iff (rst)
      (strobe.stepUp && opThread == THREAD_W'(t)) |=> cwpQ[t] == $past(cwpQ[t]) + WIN_W'(1));
    p_ptr_hold_r13: assert property (@(posedge clk) disable iff (rst)
      !((strobe.stepDown || strobe.stepUp) && opThread == THREAD_W'(t)) |=> $stable(cwpQ[t]));
  end

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    p_zero_read_r2: assert property (@(posedge clk) disable iff (rst)
      rdReg[p] == '0 |-> rdData[p] == '0);
  end

  p_port0_wins_r11: assert property (@(posedge clk) disable iff (rst)
    (wrEn[0] && wrEn[1] && wrReg[0] != '0 && wrIdx[0] == wrIdx[1])
      |=> store[$past(wrIdx[0])] == $past(wrData[0]));
endmodule

// File: rtl/rwin_regfile.sv
module rwin_regfile
  import rwin_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int NUM_WINDOWS = 8,
  parameter int DATA_W = 32,
  parameter int NUM_RD = 3,
  parameter int NUM_WR = 2,
  parameter int THREAD_W = $clog2(NUM_THREADS),
  parameter int WIN_W = $clog2(NUM_WINDOWS)
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [NUM_RD-1:0][THREAD_W-1:0]   rdThread,
  input  logic [NUM_RD-1:0][4:0]            rdReg,
  output logic [NUM_RD-1:0][DATA_W-1:0]     rdData,
  input  logic [NUM_WR-1:0]                 wrEn,
  input  logic [NUM_WR-1:0][THREAD_W-1:0]   wrThread,
  input  logic [NUM_WR-1:0][4:0]            wrReg,
  input  logic [NUM_WR-1:0][DATA_W-1:0]     wrData,
  input  logic                              saveEn,
  input  logic                              restoreEn,
  input  logic [THREAD_W-1:0]               opThread,
  output logic [NUM_THREADS-1:0][WIN_W-1:0] winPtr,
  output logic [NUM_THREADS-1:0]            overflowFlag,
  output logic [NUM_THREADS-1:0]            underflowFlag
);
  winStrobe_t strobe;

  rwin_ctrl #(
    .NUM_THREADS(NUM_THREADS), .NUM_WINDOWS(NUM_WINDOWS), .THREAD_W(THREAD_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .saveEn(saveEn), .restoreEn(restoreEn),
    .opThread(opThread), .strobe(strobe),
    .overflowFlag(overflowFlag), .underflowFlag(underflowFlag)
  );

  rwin_datapath #(
    .NUM_THREADS(NUM_THREADS), .NUM_WINDOWS(NUM_WINDOWS), .DATA_W(DATA_W),
    .NUM_RD(NUM_RD), .NUM_WR(NUM_WR), .THREAD_W(THREAD_W), .WIN_W(WIN_W)
  ) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .opThread(opThread),
    .rdThread(rdThread), .rdReg(rdReg), .rdData(rdData),
    .wrEn(wrEn), .wrThread(wrThread), .wrReg(wrReg), .wrData(wrData),
    .winPtr(winPtr)
  );
endmodule

// File: tb/tb_rwin_regfile.sv
`timescale 1ns/1ps
module tb_rwin_regfile;
  localparam int NT = 4;
  localparam int NW = 8;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst;
  logic [2:0][1:0]  rdThread;
  logic [2:0][4:0]  rdReg;
  logic [2:0][31:0] rdData;
  logic [1:0]       wrEn;
  logic [1:0][1:0]  wrThread;
  logic [1:0][4:0]  wrReg;
  logic [1:0][31:0] wrData;
  logic             saveEn, restoreEn;
  logic [1:0]       opThread;
  logic [3:0][2:0]  winPtr;
  logic [3:0]       overflowFlag, underflowFlag;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  logic [31:0] mGlob [NT][8];
  logic [31:0] mWin  [NT][NW][16];
  int cwpM [NT];
  int depthM [NT];

  always #4 clk = ~clk;

  rwin_regfile dut (
    .clk(clk), .rst(rst), .rdThread(rdThread), .rdReg(rdReg), .rdData(rdData),
    .wrEn(wrEn), .wrThread(wrThread), .wrReg(wrReg), .wrData(wrData),
    .saveEn(saveEn), .restoreEn(restoreEn), .opThread(opThread),
    .winPtr(winPtr), .overflowFlag(overflowFlag), .underflowFlag(underflowFlag)
  );

  function automatic logic [31:0] mRead(int t, int r);
    int c = cwpM[t];
    if (r == 0) return '0;
    if (r < 8)  return mGlob[t][r];
    if (r < 16) return mWin[t][c][r-8];
    if (r < 24) return mWin[t][c][8 + r - 16];
    return mWin[t][(c + 1) % NW][r-24];
  endfunction

  task automatic mWrite(int t, int r, logic [31:0] d);
    int c = cwpM[t];
    if (r == 0) return;
    if (r < 8)       mGlob[t][r] = d;
    else if (r < 16) mWin[t][c][r-8] = d;
    else if (r < 24) mWin[t][c][8 + r - 16] = d;
    else             mWin[t][(c + 1) % NW][r-24] = d;
  endtask

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic idle();
    wrEn = '0; saveEn = 0; restoreEn = 0;
  endtask

  // one cycle: check reads, update model, check pointers and flags
  task automatic cyc(string tag);
    logic [3:0] eo, eu;
    logic [3:0][2:0] ep;
    int t;
    #1;
    for (int p = 0; p < 3; p++)
      chk(tag, $sformatf("read port %0d", p), 64'(rdData[p]),
          64'(mRead(int'(rdThread[p]), int'(rdReg[p]))));
    if (wrEn[1]) mWrite(int'(wrThread[1]), int'(wrReg[1]), wrData[1]);
    if (wrEn[0]) mWrite(int'(wrThread[0]), int'(wrReg[0]), wrData[0]);
    eo = '0; eu = '0; t = int'(opThread);
    if (saveEn && !restoreEn) begin
      if (depthM[t] == NW - 2) eo[t] = 1'b1;
      else begin cwpM[t] = (cwpM[t] + NW - 1) % NW; depthM[t]++; end
    end else if (restoreEn && !saveEn) begin
      if (depthM[t] == 0) eu[t] = 1'b1;
      else begin cwpM[t] = (cwpM[t] + 1) % NW; depthM[t]--; end
    end
    @(posedge clk); #1;
    for (int i = 0; i < NT; i++) ep[i] = 3'(cwpM[i]);
    chk(tag, "overflowFlag", 64'(overflowFlag), 64'(eo));
    chk(tag, "underflowFlag", 64'(underflowFlag), 64'(eu));
    chk(tag, "winPtr", 64'(winPtr), 64'(ep));
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int t = 0; t < NT; t++) begin
      cwpM[t] = 0; depthM[t] = 0;
      for (int r = 0; r < 8; r++) mGlob[t][r] = '0;
      for (int w = 0; w < NW; w++) for (int s = 0; s < 16; s++) mWin[t][w][s] = '0;
    end
    void'($urandom(32'd2024));
    rst = 1; idle(); opThread = '0; wrThread = '0; wrReg = '0; wrData = '0;
    rdThread = '0; rdReg = '0;
    repeat (3) @(negedge clk);
    rst = 0;

    // R1: reset state
    rdThread[0] = 2'd2; rdReg[0] = 5'd5;
    rdThread[1] = 2'd3; rdReg[1] = 5'd28;
    rdThread[2] = 2'd1; rdReg[2] = 5'd17;
    cyc("R1");

    // R2: write to register 0 ignored
    wrEn = 2'b01; wrThread[0] = 2'd0; wrReg[0] = 5'd0; wrData[0] = 32'hdeadbeef;
    rdThread = '0; rdReg = '0;
    cyc("R2");
    idle(); cyc("R2");

    // R11: same target on both write ports
    wrEn = 2'b11; wrThread[0] = 2'd1; wrThread[1] = 2'd1;
    wrReg[0] = 5'd17; wrReg[1] = 5'd17;
    wrData[0] = 32'haaaa0001; wrData[1] = 32'hbbbb0002;
    cyc("R11");
    idle(); rdThread[0] = 2'd1; rdReg[0] = 5'd17; cyc("R11");

    // R12 / R5: write an out register together with a save
    wrEn = 2'b01; wrThread[0] = 2'd0; wrReg[0] = 5'd10; wrData[0] = 32'hc0ffee00;
    saveEn = 1; opThread = 2'd0;
    cyc("R12");
    idle(); rdThread[0] = 2'd0; rdReg[0] = 5'd26; cyc("R5");

    // R4 / R3: local and global in the saved window, then restore
    wrEn = 2'b11; wrThread[0] = 2'd0; wrReg[0] = 5'd20; wrData[0] = 32'h0000d00d;
    wrThread[1] = 2'd0; wrReg[1] = 5'd3; wrData[1] = 32'h0000e00e;
    cyc("R4");
    idle(); restoreEn = 1; opThread = 2'd0;
    rdThread[0] = 2'd0; rdReg[0] = 5'd20; rdThread[1] = 2'd1; rdReg[1] = 5'd3;
    cyc("R4");
    idle(); rdThread[1] = 2'd0; rdReg[2] = 5'd10; rdThread[2] = 2'd0;
    cyc("R3");

    // R7: saves up to and past the limit on thread 3
    for (int i = 0; i < 7; i++) begin
      saveEn = 1; opThread = 2'd3; cyc("R7");
    end
    idle(); cyc("R7");

    // R8: restore with nothing saved on thread 2
    restoreEn = 1; opThread = 2'd2; cyc("R8");
    idle(); saveEn = 1; opThread = 2'd2; cyc("R13");

    // R9: both commands together
    idle(); saveEn = 1; restoreEn = 1; opThread = 2'd1; cyc("R9");

    // R6: restores on thread 3
    idle(); restoreEn = 1; opThread = 2'd3; cyc("R6"); cyc("R6");

    // R10: constrained random traffic
    for (int n = 0; n < 3000; n++) begin
      int op;
      for (int p = 0; p < 3; p++) begin
        rdThread[p] = 2'($urandom % NT); rdReg[p] = 5'($urandom % 32);
      end
      for (int p = 0; p < 2; p++) begin
        wrEn[p] = 1'($urandom % 2);
        wrThread[p] = 2'($urandom % NT); wrReg[p] = 5'($urandom % 32);
        wrData[p] = $urandom;
      end
      if ($urandom % 4 == 0) begin wrThread[1] = wrThread[0]; wrReg[1] = wrReg[0]; end
      op = $urandom % 8;
      saveEn = (op < 2) || (op == 4);
      restoreEn = (op == 2) || (op == 3) || (op == 4);
      opThread = 2'($urandom % NT);
      cyc("R10");
    end

    finished = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule